// File: doc/BRIEF.md
# Serial Configuration Loader with Destination Routing

This block takes configuration words from a three-wire serial port made of a serial clock, a data line and a load-enable line. All three pins are resynchronised into the block's own clock domain. Each rising edge of the serial clock appends one data bit to an internal shift register, with the most significant bit first. A rising edge of load-enable copies the register into one of two parallel holding latches. The last bit received before the load, the destination bit, picks which latch.

With the destination bit at 0, the 18 bits before it become the main-divider setting. That setting is an 11-bit program count followed by a 7-bit swallow count. With the destination bit at 1, the 15 bits before it become the reference setting. That setting is one prescaler-select bit followed by a 14-bit reference count. Each latch update raises a one-cycle strobe for the latch that was written. Loading a program count below its floor, or a reference count below its floor, sets a sticky range-error flag. Load-enable rests high when left undriven, so a level that is already high must not cause a load.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, all latched fields read 0, both strobes are low and the range-error flag is low.
- R2: Each rising edge of `ser_clk` appends the current `ser_data` bit to the shift register as its newest bit. Words are sent most significant bit first.
- R3: On a load with destination bit 0, `div_prog` takes the first 11 of the 18 bits that precede the destination bit and `div_swallow` takes the following 7 bits.
- R4: On a load with destination bit 1, `ref_presc_sel` takes the first of the 15 bits that precede the destination bit and `ref_count` takes the following 14 bits.
- R5: Latch contents change only on a low-to-high transition of `ser_le`. Shifting with `ser_le` low or held high leaves both latches unchanged.
- R6: A `ser_le` level that is high from reset onward causes no load until it has been low and risen again.
- R7: Each load pulses exactly one of `div_load_stb` or `ref_load_stb` for one cycle, in the cycle the matching latch shows its new value.
- R8: With two synchroniser stages, a `ser_le` rise that is present before clock edge k shows in the latch and strobe after edge k+2.
- R9: `range_err` goes high when a load writes a program count below 16 or a reference count below 8. It stays high until reset, whatever is loaded afterwards.
- R10: When the `ser_le` rise and a `ser_clk` rise reach the block in the same cycle, the loaded word excludes the coincident bit. That bit is still shifted in.
- R11: A stream longer than a word loads only its most recent bits. Earlier bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit (asynchronous) |
| ser_le | input | 1 | Load enable, rising edge transfers (asynchronous) |
| div_swallow | output | 7 | Latched swallow count |
| div_prog | output | 11 | Latched program count |
| ref_count | output | 14 | Latched reference count |
| ref_presc_sel | output | 1 | Latched prescaler-pair select |
| div_load_stb | output | 1 | One-cycle pulse on divider latch update |
| ref_load_stb | output | 1 | One-cycle pulse on reference latch update |
| range_err | output | 1 | Sticky out-of-range flag |

## Verification
The delicate overlap is a shift and a load landing in the same cycle. The bench provokes it by driving the serial-clock rise and the load-enable rise on the same clock edge, after a divider word has been fully shifted. The divider latch must show that complete word, without the bit being shifted in at that moment. A second load pulse must then show that the bit did arrive: the destination bit has flipped to 1, and the reference fields equal a hand-computed value taken from the shifted word. A queue-based reference model is also compared on every clock. It catches any other overlap between loads, range-error setting and shifting.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Destination selected by the trailing bit of a serial word
  typedef enum logic {
    DEST_DIV = 1'b0,
    DEST_REF = 1'b1
  } dest_e;

  // True when a latched count falls below the lowest legal value
  function automatic logic under_floor(input logic [31:0] value,
                                       input logic [31:0] floor_val);
    return value < floor_val;
  endfunction

  // Upper field of a word whose lower field is lo_w bits wide
  function automatic logic [31:0] upper_part(input logic [31:0] word,
                                             input int        lo_w);
    return word >> lo_w;
  endfunction

  // Lower lo_w bits of a word
  function automatic logic [31:0] lower_part(input logic [31:0] word,
                                             input int        lo_w);
    return word & ((32'd1 << lo_w) - 32'd1);
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        chain[i] <= chain[i-1];
      end
      chain[0] <= pin_in;
    end
  end

  assign level = chain[STAGES-1];

endmodule

// File: rtl/cfg_rise_det.sv
module cfg_rise_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RST_VAL;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end

endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_loader_pkg::*;
#(
  parameter int SWAL_W   = 7,
  parameter int PROG_W   = 11,
  parameter int REF_W    = 14,
  parameter int PROG_MIN = 16,
  parameter int REF_MIN  = 8,
  localparam int DIV_W   = SWAL_W + PROG_W,
  localparam int REFWD_W = REF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_div,
  input  logic               load_ref,
  input  logic [DIV_W-1:0]   div_word,
  input  logic [REFWD_W-1:0] ref_word,
  output logic [SWAL_W-1:0]  div_swallow,
  output logic [PROG_W-1:0]  div_prog,
  output logic [REF_W-1:0]   ref_count,
  output logic               ref_presc_sel,
  output logic               div_load_stb,
  output logic               ref_load_stb,
  output logic               range_err
);

  logic [PROG_W-1:0] prog_in;
  logic [SWAL_W-1:0] swal_in;
  logic [REF_W-1:0]  count_in;
  logic              sel_in;
  logic              bad_div;
  logic              bad_ref;

  always_comb begin
    prog_in  = PROG_W'(upper_part(32'(div_word), SWAL_W));
    swal_in  = SWAL_W'(lower_part(32'(div_word), SWAL_W));
    sel_in   = ref_word[REFWD_W-1];
    count_in = REF_W'(lower_part(32'(ref_word), REF_W));
    bad_div  = load_div && under_floor(32'(prog_in), 32'(PROG_MIN));
    bad_ref  = load_ref && under_floor(32'(count_in), 32'(REF_MIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_prog    <= '0;
      div_swallow <= '0;
    end else if (load_div) begin
      div_prog    <= prog_in;
      div_swallow <= swal_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_count     <= '0;
      ref_presc_sel <= 1'b0;
    end else if (load_ref) begin
      ref_count     <= count_in;
      ref_presc_sel <= sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_load_stb <= 1'b0;
      ref_load_stb <= 1'b0;
      range_err    <= 1'b0;
    end else begin
      div_load_stb <= load_div;
      ref_load_stb <= load_ref;
      range_err    <= range_err | bad_div | bad_ref;
    end
  end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SWAL_W      = 7,
  parameter int PROG_W      = 11,
  parameter int REF_W       = 14,
  parameter int PROG_MIN    = 16,
  parameter int REF_MIN     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [SWAL_W-1:0] div_swallow,
  output logic [PROG_W-1:0] div_prog,
  output logic [REF_W-1:0]  ref_count,
  output logic              ref_presc_sel,
  output logic              div_load_stb,
  output logic              ref_load_stb,
  output logic              range_err
);

  localparam int DIV_W   = SWAL_W + PROG_W;
  localparam int REFWD_W = REF_W + 1;
  localparam int SR_W    = DIV_W + 1;
  localparam int N_PINS  = 3;
  // pin order: [0] serial clock, [1] data, [2] load enable (rests high)
  localparam logic [N_PINS-1:0] PIN_RST = 3'b100;

  logic [N_PINS-1:0] pins_raw;
  logic [N_PINS-1:0] pins_sync;
  logic [SR_W-1:0]   sr_word;

  // Named internal events, observed by the bound checker
  logic  shift_evt;
  logic  load_evt;
  logic  data_level;
  dest_e dest;
  logic  load_div;
  logic  load_ref;

  assign pins_raw = {ser_le, ser_data, ser_clk};

  for (genvar p = 0; p < N_PINS; p++) begin : g_sync
    cfg_pin_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_RST[p])
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_in(pins_raw[p]),
      .level (pins_sync[p])
    );
  end

  cfg_rise_det #(.RST_VAL(PIN_RST[0])) u_clk_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .level(pins_sync[0]),
    .rise (shift_evt)
  );

  cfg_rise_det #(.RST_VAL(PIN_RST[2])) u_le_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .level(pins_sync[2]),
    .rise (load_evt)
  );

  assign data_level = pins_sync[1];

  cfg_shift_reg #(.W(SR_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_evt),
    .bit_in  (data_level),
    .word    (sr_word)
  );

  always_comb begin
    dest     = dest_e'(sr_word[0]);
    load_div = load_evt && (dest == DEST_DIV);
    load_ref = load_evt && (dest == DEST_REF);
  end

  cfg_latch_bank #(
    .SWAL_W  (SWAL_W),
    .PROG_W  (PROG_W),
    .REF_W   (REF_W),
    .PROG_MIN(PROG_MIN),
    .REF_MIN (REF_MIN)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_div     (load_div),
    .load_ref     (load_ref),
    .div_word     (sr_word[SR_W-1:1]),
    .ref_word     (sr_word[REFWD_W:1]),
    .div_swallow  (div_swallow),
    .div_prog     (div_prog),
    .ref_count    (ref_count),
    .ref_presc_sel(ref_presc_sel),
    .div_load_stb (div_load_stb),
    .ref_load_stb (ref_load_stb),
    .range_err    (range_err)
  );

endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
  parameter int SWAL_W   = 7,
  parameter int PROG_W   = 11,
  parameter int REF_W    = 14,
  parameter int PROG_MIN = 16,
  parameter int REF_MIN  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_evt,
  input logic              load_evt,
  input logic              dest_bit,
  input logic              data_level,
  input logic              sr_lsb,
  input logic [SWAL_W-1:0] div_swallow,
  input logic [PROG_W-1:0] div_prog,
  input logic [REF_W-1:0]  ref_count,
  input logic              ref_presc_sel,
  input logic              div_load_stb,
  input logic              ref_load_stb,
  input logic              range_err
);

  p_shift_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (sr_lsb == $past(data_level)));

  p_route_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !dest_bit) |=> (div_load_stb && !ref_load_stb));

  p_route_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && dest_bit) |=> (ref_load_stb && !div_load_stb));

  p_hold_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_load_stb |-> ($stable(div_prog) && $stable(div_swallow)));

  p_hold_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_load_stb |-> ($stable(ref_count) && $stable(ref_presc_sel)));

  p_one_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_load_stb && ref_load_stb));

  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_load_stb || ref_load_stb) |-> $past(load_evt));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(range_err) |->
      ((div_load_stb && (32'(div_prog) < PROG_MIN)) ||
       (ref_load_stb && (32'(ref_count) < REF_MIN))));

endmodule

bind serial_cfg_loader cfg_loader_checker #(
  .SWAL_W  (SWAL_W),
  .PROG_W  (PROG_W),
  .REF_W   (REF_W),
  .PROG_MIN(PROG_MIN),
  .REF_MIN (REF_MIN)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_evt    (shift_evt),
  .load_evt     (load_evt),
  .dest_bit     (sr_word[0]),
  .data_level   (data_level),
  .sr_lsb       (sr_word[0]),
  .div_swallow  (div_swallow),
  .div_prog     (div_prog),
  .ref_count    (ref_count),
  .ref_presc_sel(ref_presc_sel),
  .div_load_stb (div_load_stb),
  .ref_load_stb (ref_load_stb),
  .range_err    (range_err)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_le = 1'b1;
  logic [6:0]  div_swallow;
  logic [10:0] div_prog;
  logic [13:0] ref_count;
  logic        ref_presc_sel;
  logic        div_load_stb;
  logic        ref_load_stb;
  logic        range_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int n_div  = 0;
  int n_ref  = 0;

  always #2 clk = ~clk;

  serial_cfg_loader i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .div_swallow(div_swallow), .div_prog(div_prog),
    .ref_count(ref_count), .ref_presc_sel(ref_presc_sel),
    .div_load_stb(div_load_stb), .ref_load_stb(ref_load_stb),
    .range_err(range_err)
  );

  task automatic check(input string tag, input int act, input int exp,
                       input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t",
               tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit rx_bits[$];
  int m_prog, m_swal, m_ref, m_sel;
  bit m_dstb, m_rstb, m_err, live;
  bit h1c, h2c, h3c, h1d, h2d, h1l, h2l, h3l;

  function automatic int tail(input int skip, input int n);
    int v = 0;
    for (int i = 0; i < n; i++) begin
      int idx = rx_bits.size() - 1 - skip - i;
      if (idx >= 0 && rx_bits[idx]) v |= (1 << i);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rx_bits.delete();
      m_prog = 0; m_swal = 0; m_ref = 0; m_sel = 0;
      m_dstb = 0; m_rstb = 0; m_err = 0; live = 0;
      h1c = 0; h2c = 0; h3c = 0; h1d = 0; h2d = 0;
      h1l = 1; h2l = 1; h3l = 1;
    end else begin
      int w;
      live = 1; m_dstb = 0; m_rstb = 0;
      if (h2l && !h3l) begin
        if (tail(0, 1) == 1) begin
          w = tail(1, 15);
          m_ref = w % 16384; m_sel = w / 16384; m_rstb = 1;
          if (m_ref < 8) m_err = 1;
        end else begin
          w = tail(1, 18);
          m_prog = w / 128; m_swal = w % 128; m_dstb = 1;
          if (m_prog < 16) m_err = 1;
        end
      end
      if (h2c && !h3c) begin
        rx_bits.push_back(h2d);
        if (rx_bits.size() > 19) void'(rx_bits.pop_front());
      end
      h3c = h2c; h2c = h1c; h1c = ser_clk;
      h2d = h1d; h1d = ser_data;
      h3l = h2l; h2l = h1l; h1l = ser_le;
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      check("R3", div_prog, m_prog, "model divider program count");
      check("R3", div_swallow, m_swal, "model divider swallow count");
      check("R4", ref_count, m_ref, "model reference count");
      check("R4", ref_presc_sel, m_sel, "model prescaler select");
      check("R7", div_load_stb, m_dstb, "model divider strobe");
      check("R7", ref_load_stb, m_rstb, "model reference strobe");
      check("R9", range_err, m_err, "model range error");
    end
    if (rst_n) begin
      if (div_load_stb) n_div++;
      if (ref_load_stb) n_ref++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) ser_data = v[i];
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic load_pulse(input bit timing);
    @(negedge clk) ser_le = 1'b1;
    @(negedge clk);
    if (timing) check("R8", div_load_stb | ref_load_stb, 0, "strobe after 1 edge");
    @(negedge clk);
    if (timing) check("R8", div_load_stb | ref_load_stb, 0, "strobe after 2 edges");
    @(negedge clk);
    if (timing) check("R8", div_load_stb | ref_load_stb, 1, "strobe after 3 edges");
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] div_word(input int prog, input int swal);
    return (prog << 8) | (swal << 1);
  endfunction

  function automatic logic [31:0] ref_word(input int sel, input int cnt);
    return (sel << 15) | (cnt << 1) | 1;
  endfunction

  initial begin
    int d0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", div_prog + div_swallow + ref_count + ref_presc_sel, 0, "fields after reset");
    check("R1", div_load_stb + ref_load_stb + range_err, 0, "flags after reset");
    repeat (10) @(negedge clk);
    check("R6", n_div + n_ref, 0, "no load from resting-high enable");
    ser_le = 1'b0;
    repeat (4) @(negedge clk);

    // R3 / R8 / R7: divider word
    d0 = n_div; r0 = n_ref;
    send_bits(div_word(300, 77), 19);
    load_pulse(1);
    check("R3", div_prog, 300, "program count");
    check("R3", div_swallow, 77, "swallow count");
    check("R7", n_div - d0, 1, "one divider strobe");
    check("R7", n_ref - r0, 0, "no reference strobe");
    check("R2", range_err, 0, "legal divider word");

    // R4: reference word
    send_bits(ref_word(1, 5000), 16);
    load_pulse(1);
    check("R4", ref_count, 5000, "reference count");
    check("R4", ref_presc_sel, 1, "prescaler select");
    check("R5", div_prog, 300, "divider held across reference load");

    // R5: shifting with enable low, then with enable held high
    send_bits(div_word(999, 3), 19);
    check("R5", div_prog, 300, "shift with enable low");
    @(negedge clk) ser_le = 1'b1;
    repeat (6) @(negedge clk);
    check("R5", div_prog, 999, "load of new word");
    r0 = n_ref;
    send_bits(ref_word(0, 100), 16);
    check("R5", ref_count, 5000, "shift with enable held high");
    check("R5", n_ref - r0, 0, "no reference strobe while held high");
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
    load_pulse(0);
    check("R5", ref_count, 100, "reference load after new rise");
    check("R5", ref_presc_sel, 0, "prescaler select cleared");

    // R11: leading surplus bits are discarded
    send_bits(32'hF, 4);
    send_bits(div_word(2047, 127), 19);
    load_pulse(0);
    check("R11", div_prog, 2047, "program count after long stream");
    check("R11", div_swallow, 127, "swallow after long stream");

    // R10: load and shift reach the block in the same cycle
    send_bits(div_word(100, 5), 19);
    d0 = n_div;
    @(negedge clk) ser_data = 1'b1;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1; ser_le = 1'b1;
    repeat (8) @(negedge clk);
    check("R10", div_prog, 100, "coincident load program count");
    check("R10", div_swallow, 5, "coincident load swallow");
    check("R10", n_div - d0, 1, "coincident load strobe");
    ser_clk = 1'b0; ser_le = 1'b0;
    repeat (4) @(negedge clk);
    r0 = n_ref;
    load_pulse(0);
    check("R10", n_ref - r0, 1, "coincident bit became destination");
    check("R10", ref_count, 9226, "reference from shifted word");
    check("R10", ref_presc_sel, 1, "prescaler from shifted word");

    // R9: range error
    check("R9", range_err, 0, "no error so far");
    send_bits(div_word(15, 0), 19);
    load_pulse(0);
    check("R9", range_err, 1, "program count 15 flagged");
    check("R9", div_prog, 15, "low program count still latched");
    send_bits(ref_word(0, 8), 16);
    load_pulse(0);
    check("R9", range_err, 1, "flag sticky after legal load");

    @(negedge clk) rst_n = 1'b0;
    ser_le = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", range_err, 0, "flag cleared by reset");
    check("R1", div_prog, 0, "divider cleared by reset");
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
    send_bits(div_word(16, 0), 19);
    load_pulse(0);
    check("R9", range_err, 0, "program count 16 legal");
    send_bits(ref_word(0, 8), 16);
    load_pulse(0);
    check("R9", range_err, 0, "reference count 8 legal");
    send_bits(ref_word(0, 7), 16);
    load_pulse(0);
    check("R9", range_err, 1, "reference count 7 flagged");

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule